// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block tells a memory controller when to send AUTO REFRESH commands. A free-running divider produces one tick per nominal refresh interval, about 15.6 µs, so that 4096 refreshes fit into each 64 ms window. Every tick adds one owed refresh to a saturating counter. While anything is owed, the block raises a request toward the command arbiter. The arbiter answers with a grant, and it also reports whether every bank is precharged. A refresh goes out only when the request, the grant and the all-banks-idle indication are present together and no earlier refresh is still completing.

Owed refreshes may pile up to eight, which lets the controller postpone refresh during busy traffic. It can then drain the backlog as a burst of back-to-back commands, each spaced by the refresh cycle time. When seven are owed, an urgent flag tells the arbiter to precharge every bank and grant refresh before the ceiling is reached. After each command, a busy output holds the command bus for the refresh cycle time, given in clocks. The command pins carry the AUTO REFRESH code during the issue cycle and a deselect code at all other times.

Top module: `refresh_sched`

## Requirements
- R1: Reset is synchronous and active high. While it is held, and in the first cycle after it, ref_req, ref_urgent, ref_strobe and busy are 0 and cs_n, ras_n, cas_n and we_n are all 1.
- R2: One refresh becomes owed every TICK_CYCLES clocks. ref_req is 1 exactly when at least one refresh is owed. After reset is released, ref_req first rises in the cycle after rising clock edge TICK_CYCLES+1 and not before.
- R3: The owed count saturates at MAX_OWED (8), and ticks that arrive while it is full are lost. Draining from saturation yields exactly MAX_OWED strobes before ref_req falls.
- R4: ref_urgent is 1 exactly when at least URGENT_LEVEL (7) refreshes are owed. It rises one edge after the seventh tick is counted, and it falls once an issued refresh brings the count back to 6.
- R5: A refresh is issued at a rising edge only if ref_req, grant and all_idle are all 1 and busy is 0 in the cycle before that edge. A grant while banks are not idle, or all_idle without a grant, issues nothing and leaves the owed count unchanged.
- R6: ref_strobe is 1 for exactly the one cycle after the issuing edge. busy is 1 for exactly TRFC_CLKS consecutive cycles, starting with the strobe cycle. Under a continuous grant, strobes are spaced exactly TRFC_CLKS+1 cycles apart.
- R7: In the strobe cycle the pins read cs_n=0, ras_n=0, cas_n=0, we_n=1, which is the AUTO REFRESH code. In every other cycle all four pins are 1.
- R8: When a tick and an issued refresh fall on the same edge, the owed count is unchanged. This holds also when the count is at MAX_OWED.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| grant | input | 1 | Arbiter grants the command bus to refresh |
| all_idle | input | 1 | Every bank is precharged |
| ref_req | output | 1 | At least one refresh is owed |
| ref_urgent | output | 1 | Owed count has reached the urgent level |
| ref_strobe | output | 1 | One-cycle pulse marking an issued AUTO REFRESH |
| busy | output | 1 | Command bus held for the refresh cycle time |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |

## Verification
An interval tick and an issued refresh can land on the same clock edge, and the owed count must then stay where it was. The bench provokes this by holding off the grant until a known count has built up. It then grants for a single cycle, placed so that the resulting issue edge is also the edge that counts a tick. This is done once mid-range and once with the counter full. The outcome is judged at the ports: the bench drains with a continuous grant and counts strobes until the request drops. The count must be 2 in the mid-range case and 8 in the full case.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam cmd_pins_t CMD_AUTOREF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam cmd_pins_t CMD_DESEL   = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

endpackage

// File: rtl/refresh_tick_gen.sv
module refresh_tick_gen #(
  parameter int TICK_CYCLES = 1560
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(TICK_CYCLES - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + CW'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/refresh_owed_ctr.sv
module refresh_owed_ctr #(
  parameter int MAX_OWED     = 8,
  parameter int URGENT_LEVEL = 7,
  localparam int OW          = $clog2(MAX_OWED + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          take,
  output logic [OW-1:0] owed,
  output logic          req,
  output logic          urgent
);
  logic [OW:0]   sum;
  logic [OW-1:0] nxt;

  // take is only raised while req is high, so sum never wraps below zero
  always_comb begin
    sum = {1'b0, owed} + (OW+1)'(tick) - (OW+1)'(take);
    if (sum > (OW+1)'(MAX_OWED)) nxt = OW'(MAX_OWED);
    else                         nxt = sum[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owed   <= '0;
      req    <= 1'b0;
      urgent <= 1'b0;
    end else begin
      owed   <= nxt;
      req    <= (nxt != '0);
      urgent <= (nxt >= OW'(URGENT_LEVEL));
    end
  end
endmodule

// File: rtl/refresh_trfc_timer.sv
module refresh_trfc_timer #(
  parameter int TRFC_CLKS = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int TW = $clog2(TRFC_CLKS + 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else begin
      if (start)           cnt <= TW'(TRFC_CLKS);
      else if (cnt != '0)  cnt <= cnt - TW'(1);
      busy <= start | (cnt > TW'(1));
    end
  end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_pkg::*;
#(
  parameter int TICK_CYCLES  = 1560,
  parameter int TRFC_CLKS    = 6,
  parameter int MAX_OWED     = 8,
  parameter int URGENT_LEVEL = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic grant,
  input  logic all_idle,
  output logic ref_req,
  output logic ref_urgent,
  output logic ref_strobe,
  output logic busy,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int OWED_W = $clog2(MAX_OWED + 1);

  logic              tick;
  logic              issue;
  logic [OWED_W-1:0] owed;
  logic              strobe_q;
  cmd_pins_t         pins_q;

  refresh_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  refresh_owed_ctr #(.MAX_OWED(MAX_OWED), .URGENT_LEVEL(URGENT_LEVEL)) u_owed (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .take   (issue),
    .owed   (owed),
    .req    (ref_req),
    .urgent (ref_urgent)
  );

  assign issue = ref_req & grant & all_idle & ~busy;

  refresh_trfc_timer #(.TRFC_CLKS(TRFC_CLKS)) u_trfc (
    .clk   (clk),
    .rst   (rst),
    .start (issue),
    .busy  (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      pins_q   <= CMD_DESEL;
    end else begin
      strobe_q <= issue;
      pins_q   <= issue ? CMD_AUTOREF : CMD_DESEL;
    end
  end

  assign ref_strobe = strobe_q;
  assign cs_n       = pins_q.cs_n;
  assign ras_n      = pins_q.ras_n;
  assign cas_n      = pins_q.cas_n;
  assign we_n       = pins_q.we_n;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int MAX_OWED     = 8,
  parameter int URGENT_LEVEL = 7,
  localparam int OW          = $clog2(MAX_OWED + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          grant,
  input logic          all_idle,
  input logic          ref_req,
  input logic          ref_urgent,
  input logic          ref_strobe,
  input logic          busy,
  input logic          cs_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic [OW-1:0] owed
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    owed <= OW'(MAX_OWED));

  assert_urgent_level_R4: assert property (@(posedge clk) disable iff (rst)
    ref_urgent == (owed >= OW'(URGENT_LEVEL)));

  assert_strobe_conditions_R5: assert property (@(posedge clk) disable iff (rst)
    ref_strobe |-> $past(ref_req && grant && all_idle && !busy));

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst)
    ref_strobe |=> !ref_strobe);

  assert_strobe_busy_R6: assert property (@(posedge clk) disable iff (rst)
    ref_strobe |-> busy);

  assert_busy_starts_with_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ref_strobe);

  assert_cmd_code_R7: assert property (@(posedge clk) disable iff (rst)
    ref_strobe |-> (!cs_n && !ras_n && !cas_n && we_n));

  assert_desel_code_R7: assert property (@(posedge clk) disable iff (rst)
    !ref_strobe |-> (cs_n && ras_n && cas_n && we_n));

  assert_req_tracks_owed_R2: assert property (@(posedge clk) disable iff (rst)
    ref_req == (owed != '0));
endmodule

bind refresh_sched refresh_sched_chk #(
  .MAX_OWED     (MAX_OWED),
  .URGENT_LEVEL (URGENT_LEVEL)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .grant      (grant),
  .all_idle   (all_idle),
  .ref_req    (ref_req),
  .ref_urgent (ref_urgent),
  .ref_strobe (ref_strobe),
  .busy       (busy),
  .cs_n       (cs_n),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .we_n       (we_n),
  .owed       (owed)
);

// File: tb/refresh_sched_test.sv
module refresh_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK       = 64;
  localparam int TRFC       = 4;
  localparam int MAXO       = 8;
  localparam int URG        = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic grant = 1'b0;
  logic all_idle = 1'b0;
  logic ref_req, ref_urgent, ref_strobe, busy, cs_n, ras_n, cas_n, we_n;

  int cyc;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  refresh_sched #(
    .TICK_CYCLES(TICK), .TRFC_CLKS(TRFC), .MAX_OWED(MAXO), .URGENT_LEVEL(URG)
  ) uut (
    .clk(clk), .rst(rst), .grant(grant), .all_idle(all_idle),
    .ref_req(ref_req), .ref_urgent(ref_urgent), .ref_strobe(ref_strobe), .busy(busy),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; grant = 1'b0; all_idle = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // holds grant and all_idle until nothing is owed; returns strobe count,
  // spacing/busy/pin flags and urgent as seen at the first two strobes
  task automatic drain(output int n, output bit gap_ok, output bit busy_ok,
                       output bit pin_ok, output bit u1, output bit u2);
    int  last = -1;
    int  run = 0;
    bit  pbusy = 1'b0;
    n = 0; gap_ok = 1; busy_ok = 1; pin_ok = 1; u1 = 0; u2 = 0;
    grant = 1'b1; all_idle = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (ref_strobe) begin
        if ({cs_n, ras_n, cas_n, we_n} != 4'b0001) pin_ok = 0;
        n++;
        if (n == 1) u1 = ref_urgent;
        if (n == 2) u2 = ref_urgent;
        if (last >= 0 && (cyc - last) != TRFC + 1) gap_ok = 0;
        last = cyc;
        if (!busy) busy_ok = 0;
      end else if ({cs_n, ras_n, cas_n, we_n} != 4'b1111) pin_ok = 0;
      if (busy && !pbusy && !ref_strobe) busy_ok = 0;
      if (busy) run++;
      else begin
        if (pbusy && run != TRFC) busy_ok = 0;
        run = 0;
      end
      pbusy = busy;
      if (!ref_req && !busy) break;
    end
    grant = 1'b0; all_idle = 1'b0;
  endtask

  task automatic test_reset();
    do_reset();
    check(!ref_req && !ref_urgent && !ref_strobe && !busy, "R1 outputs low",
          {ref_req, ref_urgent, ref_strobe, busy}, 0);
    check({cs_n, ras_n, cas_n, we_n} == 4'b1111, "R1 pins deselect",
          {cs_n, ras_n, cas_n, we_n}, 15);
  endtask

  task automatic test_accumulate();
    do_reset();
    wait_cyc(TICK);
    check(!ref_req, "R2 req before first tick counted", ref_req, 0);
    wait_cyc(TICK + 1);
    check(ref_req, "R2 req after first tick", ref_req, 1);
    wait_cyc(7*TICK);
    check(!ref_urgent, "R4 urgent at six owed", ref_urgent, 0);
    wait_cyc(7*TICK + 1);
    check(ref_urgent, "R4 urgent at seven owed", ref_urgent, 1);
  endtask

  task automatic test_saturate();
    int n; bit g, b, p, u1, u2;
    do_reset();
    wait_cyc(10*TICK + 2);
    drain(n, g, b, p, u1, u2);
    check(n == MAXO, "R3 strobes after saturation", n, MAXO);
    check(u1, "R4 urgent after first drain strobe", u1, 1);
    check(!u2, "R4 urgent after second drain strobe", u2, 0);
    check(g, "R6 strobe spacing", g, 1);
    check(b, "R6 busy length", b, 1);
    check(p, "R7 pin code", p, 1);
  endtask

  task automatic test_gating();
    int cnt = 0;
    int n; bit g, b, p, u1, u2;
    do_reset();
    wait_cyc(TICK + 2);
    grant = 1'b1; all_idle = 1'b0;
    repeat (10) begin @(negedge clk); if (ref_strobe) cnt++; end
    check(cnt == 0, "R5 no issue without idle banks", cnt, 0);
    grant = 1'b0; all_idle = 1'b1;
    cnt = 0;
    repeat (10) begin @(negedge clk); if (ref_strobe) cnt++; end
    check(cnt == 0, "R5 no issue without grant", cnt, 0);
    check(ref_req, "R5 request kept while blocked", ref_req, 1);
    drain(n, g, b, p, u1, u2);
    check(n == 1, "R5 single owed refresh drained", n, 1);
  endtask

  task automatic test_coincide(input int start_tick, input int exp_left, input string tag);
    int n; bit g, b, p, u1, u2;
    do_reset();
    wait_cyc(start_tick*TICK);
    grant = 1'b1; all_idle = 1'b1;
    @(negedge clk);
    grant = 1'b0; all_idle = 1'b0;
    check(ref_strobe, {tag, " strobe on tick edge"}, ref_strobe, 1);
    repeat (3) @(negedge clk);
    drain(n, g, b, p, u1, u2);
    check(n == exp_left, {tag, " owed count kept"}, n, exp_left);
  endtask

  initial begin
    test_reset();
    test_accumulate();
    test_saturate();
    test_gating();
    test_coincide(3, 2, "R8 mid-range");
    test_coincide(9, MAXO, "R8 R3 saturated");
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule